// File: doc/BRIEF.md
# Duty Ramp Sequencer

This block moves the duty value of one PWM channel from a starting point towards a higher or lower level without help from software. The ramp works in equal increments. A new increment is applied after a fixed number of PWM periods, and the ramp stops after a set number of increments. The channel's timer supplies a one-cycle pulse at each period boundary. The block turns those pulses into duty updates and drives the 25-bit duty word that the PWM comparator reads. The same word is available to any reader at all times.

Software places the starting duty, the increment, the period interval, the increment count and the direction on the configuration inputs. None of these values has any effect until a one-cycle start strobe arrives. The strobe clears itself, and the block captures all configuration on that edge. Afterwards the configuration inputs can change freely. The ramp then runs to completion and stops on its final value. A one-cycle done flag marks the end of the ramp. There is no data stream here, so every pin is a plain control or status signal without a handshake.

Top module: `fade_engine`

## Requirements
- R1: After reset, `duty_out` is 0, `busy` is 0 and `fade_done` is 0.
- R2: When `start` is high at a clock edge, `duty_out` takes the value of `cfg_duty` on that edge. `busy` becomes 1 on that edge if `cfg_num` is nonzero.
- R3: Changes on `cfg_duty`, `cfg_scale`, `cfg_cycle`, `cfg_num` or `cfg_up` do not alter `duty_out`, `busy` or `fade_done` when no `start` accompanies them. This holds while idle and also during a ramp, because a running ramp uses the values captured at start.
- R4: During a ramp, one increment is applied on every Nth `period_tick`, where N is the captured `cfg_cycle`. A captured value of 0 behaves as N = 1.
- R5: An increment adds the captured `cfg_scale` to `duty_out` when the captured `cfg_up` is 1. It subtracts the captured `cfg_scale` when the captured `cfg_up` is 0.
- R6: An addition whose result would exceed 2^25-1 gives 2^25-1. A subtraction whose result would fall below 0 gives 0. The value never wraps around.
- R7: After exactly `cfg_num` increments, `busy` falls on the same edge that applies the last increment. `fade_done` is 1 for exactly that one cycle, and `duty_out` then holds its final value.
- R8: A start with `cfg_num` = 0 loads `cfg_duty`, leaves `busy` at 0 and raises `fade_done` for the one cycle after the start edge.
- R9: A `start` during a running ramp abandons that ramp. The new configuration is captured and the interval count restarts from zero. `start` takes priority over a `period_tick` in the same cycle.
- R10: `duty_out` changes only on an edge where `start` or `period_tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_duty | input | 25 | Starting duty, loaded on start |
| cfg_scale | input | 10 | Increment size |
| cfg_cycle | input | 10 | Periods between increments (0 acts as 1) |
| cfg_num | input | 10 | Number of increments |
| cfg_up | input | 1 | 1 = ramp up, 0 = ramp down |
| start | input | 1 | One-cycle strobe that captures configuration and begins a ramp |
| period_tick | input | 1 | One-cycle pulse at each PWM period boundary |
| duty_out | output | 25 | Current duty value for the comparator |
| busy | output | 1 | High while a ramp is running |
| fade_done | output | 1 | One-cycle pulse when a ramp completes |

## Verification
The assertions check several properties on every cycle:
- the duty word stays unchanged when neither a tick nor a start is present;
- a start loads the starting duty;
- during a ramp the duty moves only in the captured direction;
- the interval counter stays below the captured interval;
- the done flag never appears while a ramp is still running.

Other properties can only be shown by the bench scenarios, which compare against arithmetic expectations:
- the exact count of increments;
- the spacing of N periods between increments;
- where saturation occurs at either end;
- the zero-count and zero-interval cases;
- a restart in the middle of a ramp;
- that configuration changes between starts have no effect.

// File: rtl/fade_pkg.sv
package fade_pkg;
  typedef enum logic {
    FADE_DOWN = 1'b0,
    FADE_UP   = 1'b1
  } fade_dir_e;

  typedef enum logic {
    FS_IDLE = 1'b0,
    FS_RUN  = 1'b1
  } fade_state_e;
endpackage

// File: rtl/fade_interval.sv
module fade_interval #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          enable,
  input  logic          tick,
  input  logic [CW-1:0] period_len,
  output logic          step_o
);
  logic [CW-1:0] pcnt;

  assign step_o = enable && tick && !clear && (pcnt == period_len - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (clear) begin
      pcnt <= '0;
    end else if (enable && tick) begin
      pcnt <= step_o ? '0 : pcnt + CW'(1);
    end
  end

  // Period counter never reaches the captured interval (R4)
  assert_interval_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enable && !clear |-> pcnt < period_len);
endmodule

// File: rtl/fade_step_alu.sv
module fade_step_alu #(
  parameter int unsigned DW = 25,
  parameter int unsigned SW = 10
) (
  input  logic [DW-1:0]   cur,
  input  logic [SW-1:0]   scale,
  input  fade_pkg::fade_dir_e dir,
  output logic [DW-1:0]   nxt
);
  localparam logic [DW-1:0] DMAX = '1;
  logic [DW:0]   sum;
  logic [DW-1:0] scale_ext;

  always_comb begin
    scale_ext = DW'(scale);
    sum       = {1'b0, cur} + {1'b0, scale_ext};
    if (dir == fade_pkg::FADE_UP) begin
      nxt = sum[DW] ? DMAX : sum[DW-1:0];
    end else begin
      nxt = (cur < scale_ext) ? '0 : cur - scale_ext;
    end
  end
endmodule

// File: rtl/fade_seq.sv
module fade_seq #(
  parameter int unsigned NW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] load_num,
  input  logic          step,
  output logic          busy,
  output logic          done_o
);
  fade_pkg::fade_state_e state;
  logic [NW-1:0]         remaining;

  assign busy = (state == fade_pkg::FS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= fade_pkg::FS_IDLE;
      remaining <= '0;
      done_o    <= 1'b0;
    end else if (load) begin
      remaining <= load_num;
      state     <= (load_num != '0) ? fade_pkg::FS_RUN : fade_pkg::FS_IDLE;
      done_o    <= (load_num == '0);
    end else begin
      done_o <= 1'b0;
      if (busy && step) begin
        remaining <= remaining - NW'(1);
        if (remaining == NW'(1)) begin
          state  <= fade_pkg::FS_IDLE;
          done_o <= 1'b1;
        end
      end
    end
  end

  // A running ramp always has increments left (R7)
  assert_run_has_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> remaining != '0);
  // Completion is only flagged once the ramp has stopped (R7)
  assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy);
endmodule

// File: rtl/fade_engine.sv
module fade_engine #(
  parameter int unsigned DUTY_W  = 25,
  parameter int unsigned FIELD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DUTY_W-1:0]  cfg_duty,
  input  logic [FIELD_W-1:0] cfg_scale,
  input  logic [FIELD_W-1:0] cfg_cycle,
  input  logic [FIELD_W-1:0] cfg_num,
  input  logic               cfg_up,
  input  logic               start,
  input  logic               period_tick,
  output logic [DUTY_W-1:0]  duty_out,
  output logic               busy,
  output logic               fade_done
);
  import fade_pkg::*;

  logic [DUTY_W-1:0]  duty_q;
  logic [DUTY_W-1:0]  duty_nxt;
  logic [FIELD_W-1:0] scale_q;
  logic [FIELD_W-1:0] cycle_q;
  fade_dir_e          dir_q;
  logic               step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scale_q <= '0;
      cycle_q <= FIELD_W'(1);
      dir_q   <= FADE_DOWN;
    end else if (start) begin
      scale_q <= cfg_scale;
      cycle_q <= (cfg_cycle == '0) ? FIELD_W'(1) : cfg_cycle;
      dir_q   <= cfg_up ? FADE_UP : FADE_DOWN;
    end
  end

  fade_interval #(.CW(FIELD_W)) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .enable     (busy),
    .tick       (period_tick),
    .period_len (cycle_q),
    .step_o     (step)
  );

  fade_step_alu #(.DW(DUTY_W), .SW(FIELD_W)) u_alu (
    .cur   (duty_q),
    .scale (scale_q),
    .dir   (dir_q),
    .nxt   (duty_nxt)
  );

  fade_seq #(.NW(FIELD_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_num (cfg_num),
    .step     (step),
    .busy     (busy),
    .done_o   (fade_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
    end else if (start) begin
      duty_q <= cfg_duty;
    end else if (step) begin
      duty_q <= duty_nxt;
    end
  end

  assign duty_out = duty_q;

  // Start loads the starting duty (R2)
  assert_start_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> duty_out == $past(cfg_duty));
  // Idle without start keeps duty fixed whatever the configuration does (R3)
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable(duty_out));
  // Upward ramp never lowers duty, so no wrap at the top (R5)
  assert_up_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && dir_q == FADE_UP |=> duty_out >= $past(duty_out));
  // Downward ramp never raises duty, so no wrap at zero (R6)
  assert_down_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && dir_q == FADE_DOWN |=> duty_out <= $past(duty_out));
  // Duty moves only on a start or a period boundary (R10)
  assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start && !period_tick |=> $stable(duty_out));
endmodule

// File: tb/fade_engine_tb.sv
module fade_engine_tb;
  localparam int DW = 25;
  localparam longint DMAX = (64'd1 << DW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [DW-1:0] cfg_duty = '0;
  logic [9:0]    cfg_scale = '0, cfg_cycle = '0, cfg_num = '0;
  logic          cfg_up = 1'b0, start = 1'b0, period_tick = 1'b0;
  logic [DW-1:0] duty_out;
  logic          busy, fade_done;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  longint e_duty;
  int     e_rem, e_pc, e_cyc, e_scale;
  bit     e_busy, e_done, e_up;

  always #2 clk = ~clk;

  fade_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_duty(cfg_duty), .cfg_scale(cfg_scale),
    .cfg_cycle(cfg_cycle), .cfg_num(cfg_num), .cfg_up(cfg_up), .start(start),
    .period_tick(period_tick), .duty_out(duty_out), .busy(busy), .fade_done(fade_done)
  );

  task automatic chk(input string req);
    n_chk++;
    if (duty_out !== DW'(e_duty) || busy !== e_busy || fade_done !== e_done) begin
      n_fail++;
      $display("FAIL %s: duty=%0d busy=%0b done=%0b expected duty=%0d busy=%0b done=%0b",
               req, duty_out, busy, fade_done, e_duty, e_busy, e_done);
    end
  endtask

  // One clock: inputs driven at negedge, model advanced, outputs sampled at next negedge
  task automatic cyc(input bit s, input bit t);
    start = s; period_tick = t;
    if (s) begin
      e_duty = cfg_duty; e_rem = cfg_num; e_pc = 0;
      e_cyc = (cfg_cycle == 0) ? 1 : cfg_cycle;
      e_scale = cfg_scale; e_up = cfg_up;
      e_busy = (cfg_num != 0); e_done = (cfg_num == 0);
    end else begin
      e_done = 0;
      if (t && e_busy) begin
        e_pc++;
        if (e_pc == e_cyc) begin
          e_pc = 0;
          if (e_up) e_duty = (e_duty + e_scale > DMAX) ? DMAX : e_duty + e_scale;
          else      e_duty = (e_duty < e_scale) ? 0 : e_duty - e_scale;
          e_rem--;
          if (e_rem == 0) begin e_busy = 0; e_done = 1; end
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    start = 0; period_tick = 0;
  endtask

  task automatic scramble();
    cfg_duty = cfg_duty ^ 25'h15A5A5A; cfg_scale = ~cfg_scale;
    cfg_cycle = cfg_cycle + 10'd3; cfg_num = ~cfg_num; cfg_up = ~cfg_up;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run still active, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    e_duty = 0; e_busy = 0; e_done = 0; e_rem = 0; e_pc = 0; e_cyc = 1; e_scale = 0; e_up = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset state");

    // R3: configuration changes while idle without start
    cfg_duty = 25'd12345; cfg_scale = 10'd9; cfg_cycle = 10'd1; cfg_num = 10'd4; cfg_up = 1'b1;
    for (int i = 0; i < 4; i++) begin cyc(0, 1); chk("R3 idle cfg ignored"); end

    // Sweep: scale x cycle x num x direction
    for (int si = 0; si < 4; si++)
      for (int ci = 0; ci < 3; ci++)
        for (int ni = 0; ni < 4; ni++)
          for (int d = 0; d < 2; d++) begin
            int sv[4] = '{0, 1, 7, 1023};
            int cv[3] = '{0, 1, 3};
            int nv[4] = '{0, 1, 2, 5};
            cfg_scale = sv[si]; cfg_cycle = cv[ci]; cfg_num = nv[ni]; cfg_up = d[0];
            if (d == 1) cfg_duty = (si % 2 == 1) ? DW'(DMAX - 3) : DW'(DMAX - 2000);
            else        cfg_duty = (si % 2 == 1) ? DW'(2) : DW'(1500);
            cyc(1, 0);
            chk(nv[ni] == 0 ? "R8 zero count" : "R2 start load");
            scramble();
            for (int k = 0; k < 40 && e_busy; k++) begin
              cyc(0, 1); chk("R4/R5/R6/R7 ramp step");
              cyc(0, 0); chk("R10 hold without tick");
            end
            cyc(0, 1); chk("R7 final value held");
          end

    // R9: restart mid-ramp, start beats a simultaneous tick
    cfg_duty = 25'd1000; cfg_scale = 10'd10; cfg_cycle = 10'd2; cfg_num = 10'd6; cfg_up = 1'b1;
    cyc(1, 0); chk("R9 first start");
    cyc(0, 1); chk("R9 first ramp");
    cyc(0, 1); chk("R9 first ramp");
    cyc(0, 1); chk("R9 first ramp partial");
    cfg_duty = 25'd500; cfg_scale = 10'd50; cfg_cycle = 10'd1; cfg_num = 10'd3; cfg_up = 1'b0;
    cyc(1, 1); chk("R9 restart over tick");
    scramble();
    for (int k = 0; k < 5; k++) begin cyc(0, 1); chk("R9 new ramp"); end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule